// File: doc/BRIEF.md
# Quad I/O Flash Read Target

This block is the device side of a serial flash port that answers a single fast-read command over four data lines. A host lowers the chip select and shifts in an 8-bit command on data line 0. It then sends a 24-bit address at four bits per serial clock, waits through a programmable number of dummy clocks, and reads bytes back on all four lines. The block oversamples chip select, the serial clock and the four data pins with the system clock. Each rising serial-clock edge takes input. Each falling edge after the turnaround presents the next output nibble.

Read data comes from a small internal array holding fixed content. The address advances one location per byte and wraps at the end of the array. Any other command, or a read command that arrives while the busy input is high, leaves the pins undriven until chip select rises. Raising chip select at any time ends the transfer at once.

Top module: `qspi_read_target`

## Requirements
- R1: While reset is held, and right after it, `dqOe` is 4'h0 and `dqOut` is 4'h0.
- R2: The command byte is taken from `dqIn[0]` on the first eight rising serial-clock edges after chip select falls, most significant bit first. The read command is 8'hEB. Serial-clock idle low (mode 0) and idle high (mode 3) both work.
- R3: After the command, six rising edges each take one address nibble from `dqIn[3:0]`, with `dqIn[3]` the highest bit of the nibble. The nibbles arrive from address bits 23..20 down to bits 3..0.
- R4: After the address, `dummyClocks` rising edges are skipped, and the values on `dqIn` during them have no effect on the data returned.
- R5: Each byte is returned as two nibbles, bits 7..4 first and then bits 3..0, with `dqOut[3]` carrying bit 7 and then bit 3. The byte at array index a (0..63) is (a*29 + 60) mod 256, and the index is the address mod 64.
- R6: Output nibbles change only after a falling serial-clock edge, so each nibble is steady when the host samples it on the following rising edge. The first nibble follows the falling edge after the last dummy rising edge.
- R7: The address advances by one after each byte, and index 63 is followed by index 0.
- R8: Chip select high aborts the transfer at any point, including on the same clock as a falling serial-clock edge in the data phase. Within six system clocks `dqOe` becomes 4'h0 and `dqOut` becomes 4'h0, and the next transfer starts from a fresh command.
- R9: A command other than 8'hEB keeps `dqOe` at 4'h0 until chip select rises.
- R10: If `busy` is high when the eighth command bit is taken, the read is rejected and `dqOe` stays 4'h0 until chip select rises.
- R11: `dqOe` is always either 4'h0 or 4'hF. It is 4'h0 through the command, address and dummy clocks and 4'hF through the data phase.
- R12: With `dummyClocks` equal to 0, the first nibble follows the falling edge right after the last address edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial port |
| rst_n | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| dqIn | input | 4 | Input level of the four data pins |
| busy | input | 1 | High while another device operation blocks reads |
| dummyClocks | input | DW (4) | Number of dummy clocks between address and data |
| dqOut | output | 4 | Output value of the four data pins |
| dqOe | output | 4 | Output enable of each data pin |

## Verification
The event that most needs care is chip select rising in the same system cycle as a falling serial-clock edge that would otherwise present the next data nibble. The bench provokes it by raising chip select and lowering the serial clock on the same clock edge, right after the host has sampled a high nibble. The abort must win: within six clocks both the enables and the data return to zero, and the next transfer must return correct data from its own address. A second coincidence is the byte boundary at the last array index, where the increment and the wrap to index 0 happen on the same edge. The bench judges it against bytes computed from the array formula.

// File: rtl/qrt_pkg.sv
package qrt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_IGNORE
  } qrt_state_t;

  typedef struct packed {
    logic clear;
    logic shiftOp;
    logic shiftAddr;
    logic drive;
  } qrt_strobe_t;

endpackage

// File: rtl/qrt_sync.sv
module qrt_sync #(
  parameter int WIDTH = 6,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RESET_VAL;
        else        stg[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RESET_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/qrt_ctrl.sv
module qrt_ctrl
  import qrt_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csS,
  input  logic          sckS,
  input  logic          busy,
  input  logic [DW-1:0] dummyClocks,
  input  logic          opMatch,
  output qrt_strobe_t   strb
);

  localparam int CW = (DW > 3) ? DW : 3;

  qrt_state_t    state;
  logic [CW-1:0] cnt;
  logic          sckPrev;
  logic          riseEv;
  logic          fallEv;

  assign riseEv = sckS & ~sckPrev;
  assign fallEv = ~sckS & sckPrev;

  always_comb begin
    strb = '0;
    if (csS) begin
      strb.clear = 1'b1;
    end else begin
      unique case (state)
        ST_CMD:  strb.shiftOp   = riseEv;
        ST_ADDR: strb.shiftAddr = riseEv;
        ST_DATA: strb.drive     = fallEv;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sckPrev <= 1'b0;
      state   <= ST_IDLE;
      cnt     <= '0;
    end else begin
      sckPrev <= sckS;
      if (csS) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            state <= ST_CMD;
            cnt   <= '0;
          end
          ST_CMD: if (riseEv) begin
            if (cnt == CW'(7)) begin
              cnt   <= '0;
              state <= (opMatch && !busy) ? ST_ADDR : ST_IGNORE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ADDR: if (riseEv) begin
            if (cnt == CW'(5)) begin
              cnt   <= '0;
              state <= (dummyClocks == '0) ? ST_DATA : ST_DUMMY;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DUMMY: if (riseEv) begin
            if (cnt == CW'(dummyClocks - 1'b1)) begin
              cnt   <= '0;
              state <= ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/qrt_datapath.sv
module qrt_datapath
  import qrt_pkg::*;
#(
  parameter logic [7:0] READ_OP = 8'hEB,
  parameter int MEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  qrt_strobe_t strb,
  input  logic [3:0]  dqS,
  output logic        opMatch,
  output logic [3:0]  dqOut,
  output logic [3:0]  dqOe
);

  localparam int AW = $clog2(MEM_WORDS);

  logic [7:0]    memArr [MEM_WORDS];
  logic [7:0]    opReg;
  logic [AW-1:0] addrIdx;
  logic          nibLow;
  logic [3:0]    outReg;
  logic          oeReg;
  logic [7:0]    curByte;

  for (genvar gi = 0; gi < MEM_WORDS; gi++) begin : g_mem
    assign memArr[gi] = 8'(gi * 29 + 60);
  end

  assign curByte = memArr[addrIdx];
  assign opMatch = ({opReg[6:0], dqS[0]} == READ_OP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opReg   <= '0;
      addrIdx <= '0;
      nibLow  <= 1'b0;
      outReg  <= '0;
      oeReg   <= 1'b0;
    end else if (strb.clear) begin
      opReg   <= '0;
      addrIdx <= '0;
      nibLow  <= 1'b0;
      outReg  <= '0;
      oeReg   <= 1'b0;
    end else begin
      if (strb.shiftOp)   opReg   <= {opReg[6:0], dqS[0]};
      if (strb.shiftAddr) addrIdx <= AW'({addrIdx, dqS});
      if (strb.drive) begin
        oeReg <= 1'b1;
        if (!nibLow) begin
          outReg <= curByte[7:4];
          nibLow <= 1'b1;
        end else begin
          outReg  <= curByte[3:0];
          nibLow  <= 1'b0;
          addrIdx <= addrIdx + 1'b1;
        end
      end
    end
  end

  assign dqOut = outReg;
  assign dqOe  = {4{oeReg}};

endmodule

// File: rtl/qspi_read_target.sv
module qspi_read_target
  import qrt_pkg::*;
#(
  parameter logic [7:0] READ_OP = 8'hEB,
  parameter int MEM_WORDS = 64,
  parameter int DW = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csN,
  input  logic          sck,
  input  logic [3:0]    dqIn,
  input  logic          busy,
  input  logic [DW-1:0] dummyClocks,
  output logic [3:0]    dqOut,
  output logic [3:0]    dqOe
);

  logic [5:0]  syncOut;
  logic        csS;
  logic        sckS;
  logic [3:0]  dqS;
  logic        opMatch;
  qrt_strobe_t strb;

  qrt_sync #(
    .WIDTH(6),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(6'b100000)
  ) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({csN, sck, dqIn}),
    .dout (syncOut)
  );

  assign csS  = syncOut[5];
  assign sckS = syncOut[4];
  assign dqS  = syncOut[3:0];

  qrt_ctrl #(.DW(DW)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .csS        (csS),
    .sckS       (sckS),
    .busy       (busy),
    .dummyClocks(dummyClocks),
    .opMatch    (opMatch),
    .strb       (strb)
  );

  qrt_datapath #(
    .READ_OP  (READ_OP),
    .MEM_WORDS(MEM_WORDS)
  ) dp_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .dqS    (dqS),
    .opMatch(opMatch),
    .dqOut  (dqOut),
    .dqOe   (dqOe)
  );

endmodule

// File: rtl/qrt_checker.sv
module qrt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       csN,
  input logic [3:0] dqOut,
  input logic [3:0] dqOe
);

  // R11
  oe_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dqOe == 4'h0) || (dqOe == 4'hF));

  // R8
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> (dqOe == 4'h0));

  // R8
  undriven_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dqOe == 4'h0) |-> (dqOut == 4'h0));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (dqOe == 4'h0 && dqOut == 4'h0));

endmodule

bind qspi_read_target qrt_checker chk_i (
  .clk  (clk),
  .rst_n(rst_n),
  .csN  (csN),
  .dqOut(dqOut),
  .dqOe (dqOe)
);

// File: tb/qspi_read_target_tb_top.sv
module qspi_read_target_tb_top;

  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csN = 1'b1;
  logic       sck = 1'b0;
  logic       busy = 1'b0;
  logic [3:0] dqIn = 4'h0;
  logic [3:0] dummyClocks = 4'd10;
  logic [3:0] dqOut;
  logic [3:0] dqOe;

  int    nChecks = 0;
  int    nFails = 0;
  bit    done = 1'b0;
  string curReq = "";
  logic [7:0] expQ[$];
  logic [7:0] obsQ[$];

  always #10 clk = ~clk;

  qspi_read_target dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .csN        (csN),
    .sck        (sck),
    .dqIn       (dqIn),
    .busy       (busy),
    .dummyClocks(dummyClocks),
    .dqOut      (dqOut),
    .dqOe       (dqOe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] memVal(input int idx);
    return 8'((idx % 64) * 29 + 60);
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input logic [3:0] din, output logic [3:0] dout, output logic [3:0] oe);
    dqIn = din;
    waitClk(H);
    dout = dqOut;
    oe = dqOe;
    sck = 1'b1;
    waitClk(H);
    sck = 1'b0;
  endtask

  // Monitor: pops expected bytes as observed bytes arrive (R5 R6 R7)
  initial begin
    forever begin
      wait (obsQ.size() > 0);
      begin
        logic [7:0] o;
        logic [7:0] e;
        o = obsQ.pop_front();
        e = (expQ.size() > 0) ? expQ.pop_front() : 8'hxx;
        check(o === e, {curReq, " R5 R6 data"}, 32'(o), 32'(e));
      end
    end
  end

  task automatic xfer(input bit mode3, input logic [7:0] op, input logic [23:0] addr,
                      input int dummy, input int nBytes, input bit expectData,
                      input bit abortMid, input string req);
    logic [3:0] d;
    logic [3:0] o;
    logic [3:0] hi;
    bit preOk;
    bit oeOk;
    int base;
    curReq = req;
    base = int'(addr % 24'd64);
    dummyClocks = 4'(dummy);
    if (expectData)
      for (int k = 0; k < nBytes; k++) expQ.push_back(memVal(base + k));
    sck = mode3;
    waitClk(2);
    csN = 1'b0;
    if (mode3) begin
      waitClk(H);
      sck = 1'b0;
    end
    preOk = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick({3'(i), op[i]}, d, o);           // R2: upper lines carry noise
      if (o != 4'h0) preOk = 1'b0;
    end
    for (int n = 5; n >= 0; n--) begin
      tick(addr[n*4 +: 4], d, o);           // R3
      if (o != 4'h0) preOk = 1'b0;
    end
    for (int j = 0; j < dummy; j++) begin
      tick(4'(j * 7 + 3), d, o);            // R4: noise during dummy clocks
      if (o != 4'h0) preOk = 1'b0;
    end
    check(preOk, {req, " R11 undriven before turnaround"}, 32'(o), 32'h0);
    oeOk = 1'b1;
    for (int b = 0; b < nBytes; b++) begin
      tick(4'h0, hi, o);
      if (o != (expectData ? 4'hF : 4'h0)) oeOk = 1'b0;
      tick(4'h0, d, o);
      if (o != (expectData ? 4'hF : 4'h0)) oeOk = 1'b0;
      if (expectData) obsQ.push_back({hi, d});
    end
    check(oeOk, {req, expectData ? " R11 driven in data" : " R9 R10 stays undriven"},
          32'(o), expectData ? 32'hF : 32'h0);
    if (abortMid) begin
      dqIn = 4'h0;
      waitClk(H);
      hi = dqOut;
      sck = 1'b1;
      check(hi == memVal(base + nBytes) >> 4, {req, " R8 high nibble before abort"},
            32'(hi), 32'(memVal(base + nBytes) >> 4));
      waitClk(H);
      sck = 1'b0;
      csN = 1'b1;                           // R8: release on the falling edge
      waitClk(6);
      check(dqOe == 4'h0 && dqOut == 4'h0, {req, " R8 abort clears pins"},
            32'({dqOe, dqOut}), 32'h0);
      sck = mode3;
    end else begin
      waitClk(H);
      if (mode3) begin
        sck = 1'b1;
        waitClk(H);
      end
      csN = 1'b1;
      waitClk(6);
      check(dqOe == 4'h0, {req, " R8 release"}, 32'(dqOe), 32'h0);
    end
    waitClk(H);
    wait (obsQ.size() == 0);
    waitClk(2);
  endtask

  initial begin
    waitClk(5);
    check(dqOe == 4'h0 && dqOut == 4'h0, "R1 in reset", 32'({dqOe, dqOut}), 32'h0);
    rst_n = 1'b1;
    waitClk(4);
    check(dqOe == 4'h0 && dqOut == 4'h0, "R1 after reset", 32'({dqOe, dqOut}), 32'h0);

    xfer(1'b0, 8'hEB, 24'h000010, 10, 4, 1'b1, 1'b0, "R2 R3 R4 mode0");
    xfer(1'b1, 8'hEB, 24'hABCD3E, 10, 4, 1'b1, 1'b0, "R7 wrap mode3");
    xfer(1'b0, 8'hEB, 24'h000005, 0, 3, 1'b1, 1'b0, "R12 zero dummy");
    xfer(1'b1, 8'hEB, 24'h123421, 3, 2, 1'b1, 1'b0, "R4 three dummy mode3");
    xfer(1'b0, 8'h6B, 24'h000000, 10, 2, 1'b0, 1'b0, "R9 unknown opcode");
    busy = 1'b1;
    xfer(1'b0, 8'hEB, 24'h000000, 10, 2, 1'b0, 1'b0, "R10 busy");
    busy = 1'b0;
    xfer(1'b0, 8'hEB, 24'h000030, 10, 1, 1'b1, 1'b1, "R8 abort");
    xfer(1'b0, 8'hEB, 24'h000007, 10, 2, 1'b1, 1'b0, "R8 fresh after abort");
    xfer(1'b1, 8'hEB, 24'h00003F, 2, 2, 1'b1, 1'b0, "R7 last index mode3");

    check(expQ.size() == 0, "R5 all bytes seen", 32'(expQ.size()), 32'h0);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    waitClk(150000);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule